// File: doc/BRIEF.md
# Two-Level Priority Interrupt Vectoring Controller

This block sits between five interrupt request lines and a processor core. The five sources are, by index: 0 external line A, 1 timer A, 2 external line B, 3 timer B, and 4 serial port. Software writes two 8-bit registers. The enable register holds a master bit and one mask bit for each source. The priority register places each source in either the high or the low level. From the requests that qualify, the block picks one winner and presents it to the core as an interrupt request with a 16-bit vector address.

The core-side handshake behaves like a valid/ready pair. `irq_o` is the valid and `ack_i` is the ready. A transfer, called an accept, happens on any rising clock edge where both are high. There is no holding rule before an accept. While `ack_i` stays low, `irq_o` and `vector_o` follow the current winner, so a request that arrives later and ranks higher replaces the presented vector. After an accept, the block records the index of the accepted source and emits a one-cycle clear pulse to that source so its flag can drop. It also marks the level of that source as in service.

The two in-service bits control nesting. While a low-level handler runs, a high-level request can still interrupt it. While a high-level handler runs, nothing else is taken. A return-from-interrupt pulse ends the most recent level. Any request that was blocked stays pending and is taken later, in priority order.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, both registers read as zero in effect: `irq_o` is 0, `vector_o` is 0, `ack_src_o` is 0 and `src_clr_o` is 0, and requests raise nothing until the registers are written.
- R2: Enable bit 7 is the master enable. While it is 0, `irq_o` stays 0 whatever the other enable bits and the requests hold.
- R3: Enable bits 0..4 mask sources 0..4 respectively (1 = enabled). Enable bits 5 and 6 have no effect on any output.
- R4: Priority bits 0..4 place sources 0..4 in the high level when set and in the low level when clear. An eligible high-level request always wins over an eligible low-level request.
- R5: Within one level, the eligible source with the lowest index wins.
- R6: `irq_o` is 1 exactly when some source is eligible. `vector_o` is 0x0003 + 8 × (winner index), that is 0x0003/0x000B/0x0013/0x001B/0x0023, and it is 0 while `irq_o` is 0.
- R7: On an accept (`irq_o` and `ack_i` both high at a clock edge), from the next cycle `ack_src_o` holds the winner index until the next accept. `src_clr_o` is one-hot on that index for exactly that one cycle and zero otherwise.
- R8: While the low level is in service and the high level is not, only high-level sources can raise `irq_o`.
- R9: While the high level is in service, `irq_o` stays 0.
- R10: A `reti_i` pulse clears the high in-service bit if it is set, and otherwise clears the low bit. With neither bit set, it has no effect.
- R11: Requests that are blocked by in-service state stay pending and are presented after the matching returns, in the order of R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 5 | Request flags, index 0..4 as listed above |
| en_we_i | input | 1 | Write strobe for the enable register |
| pri_we_i | input | 1 | Write strobe for the priority register |
| wdata_i | input | 8 | Write data for both registers |
| ack_i | input | 1 | Core ready; accepts the presented interrupt |
| reti_i | input | 1 | One-cycle return-from-interrupt pulse |
| irq_o | output | 1 | Interrupt request (valid) |
| vector_o | output | 16 | Vector address of the current winner |
| ack_src_o | output | 3 | Index of the most recently accepted source |
| src_clr_o | output | 5 | One-cycle clear pulse to the accepted source |

## Verification
The bench runs a behavioural reference model every cycle. It covers the following faults, each with its visible symptom:
- A master enable that only gates the vector would leak `irq_o` while disabled.
- Treating the reserved enable bits as source masks would raise a spurious request.
- A tie-break on the wrong end of the index order would present 0x001B where 0x0013 is due.
- The nested sequence is the main target. It takes a low handler, lets a high request preempt it, issues a return that must drop only the high level, then issues a second return that releases the blocked low requests one at a time.
- A return that clears both levels, or the low one first, would show `irq_o` a cycle early.
- A clear pulse held for two cycles would show up against the single-cycle expectation.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int unsigned NSRC_DEF  = 5;
  localparam int unsigned REG_W_DEF = 8;
  localparam int unsigned VEC_W_DEF = 16;

  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } lvl_e;
endpackage

// File: rtl/irqv_regs.sv
module irqv_regs #(
  parameter int unsigned REG_W   = 8,
  parameter int unsigned NSRC    = 5,
  parameter int unsigned GEN_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_we,
  input  logic             pri_we,
  input  logic [REG_W-1:0] wdata,
  output logic             gen_en,
  output logic [NSRC-1:0]  en_mask,
  output logic [NSRC-1:0]  pri_mask
);
  logic [REG_W-1:0] en_q;
  logic [REG_W-1:0] pri_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      pri_q <= '0;
    end else begin
      if (en_we)  en_q  <= wdata;
      if (pri_we) pri_q <= wdata;
    end
  end

  assign gen_en   = en_q[GEN_BIT];
  assign en_mask  = en_q[NSRC-1:0];
  assign pri_mask = pri_q[NSRC-1:0];

  logic unused_bits;
  assign unused_bits = ^{en_q[REG_W-1:NSRC], pri_q[REG_W-1:NSRC]};
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter #(
  parameter int unsigned NSRC  = 5,
  parameter int unsigned IDX_W = 3
) (
  input  logic [NSRC-1:0]  req,
  input  logic [NSRC-1:0]  en_mask,
  input  logic [NSRC-1:0]  pri_mask,
  input  logic             gen_en,
  input  logic             ins_hi,
  input  logic             ins_lo,
  output logic             found,
  output logic [IDX_W-1:0] win_idx,
  output irqv_pkg::lvl_e   win_lvl
);
  logic [NSRC-1:0] elig_hi;
  logic [NSRC-1:0] elig_lo;

  for (genvar g = 0; g < NSRC; g++) begin : g_elig
    logic live;
    assign live       = gen_en & en_mask[g] & req[g];
    assign elig_hi[g] = live &  pri_mask[g] & ~ins_hi;
    assign elig_lo[g] = live & ~pri_mask[g] & ~ins_hi & ~ins_lo;
  end

  logic             hi_any, lo_any;
  logic [IDX_W-1:0] hi_idx, lo_idx;

  always_comb begin
    hi_any = 1'b0;
    lo_any = 1'b0;
    hi_idx = '0;
    lo_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig_hi[i]) begin
        hi_any = 1'b1;
        hi_idx = IDX_W'(i);
      end
      if (elig_lo[i]) begin
        lo_any = 1'b1;
        lo_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    found   = hi_any | lo_any;
    win_idx = hi_any ? hi_idx : lo_idx;
    win_lvl = hi_any ? irqv_pkg::LVL_HI : irqv_pkg::LVL_LO;
  end
endmodule

// File: rtl/irqv_inservice.sv
module irqv_inservice (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  irqv_pkg::lvl_e take_lvl,
  input  logic           reti,
  output logic           ins_hi,
  output logic           ins_lo
);
  logic hi_d, lo_d;

  always_comb begin
    hi_d = ins_hi;
    lo_d = ins_lo;
    if (reti) begin
      if (ins_hi) hi_d = 1'b0;
      else        lo_d = 1'b0;
    end
    if (take) begin
      if (take_lvl == irqv_pkg::LVL_HI) hi_d = 1'b1;
      else                              lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ins_hi <= 1'b0;
      ins_lo <= 1'b0;
    end else begin
      ins_hi <= hi_d;
      ins_lo <= lo_d;
    end
  end

  // R10: a return drops the high level first and leaves the low one alone
  p_reti_hi_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && ins_hi && !take) |=> (!ins_hi && (ins_lo == $past(ins_lo))));

  // R10: with only the low level active, a return clears it
  p_reti_lo_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ins_hi && !take) |=> !ins_lo);

  // R9: a high-level accept marks the high level busy
  p_take_hi_marks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_lvl == irqv_pkg::LVL_HI) |=> ins_hi);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int unsigned NSRC     = irqv_pkg::NSRC_DEF,
  parameter int unsigned REG_W    = irqv_pkg::REG_W_DEF,
  parameter int unsigned VEC_W    = irqv_pkg::VEC_W_DEF,
  parameter int unsigned GEN_BIT  = 7,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned VEC_STEP = 8,
  localparam int unsigned IDX_W   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  req_i,
  input  logic             en_we_i,
  input  logic             pri_we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             ack_i,
  input  logic             reti_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vector_o,
  output logic [IDX_W-1:0] ack_src_o,
  output logic [NSRC-1:0]  src_clr_o
);
  logic             gen_en;
  logic [NSRC-1:0]  en_mask, pri_mask;
  logic             ins_hi, ins_lo;
  logic             found;
  logic [IDX_W-1:0] win_idx;
  irqv_pkg::lvl_e   win_lvl;
  logic             take;

  irqv_regs #(.REG_W(REG_W), .NSRC(NSRC), .GEN_BIT(GEN_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .en_we(en_we_i), .pri_we(pri_we_i),
    .wdata(wdata_i), .gen_en(gen_en), .en_mask(en_mask), .pri_mask(pri_mask)
  );

  irqv_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
    .req(req_i), .en_mask(en_mask), .pri_mask(pri_mask), .gen_en(gen_en),
    .ins_hi(ins_hi), .ins_lo(ins_lo), .found(found), .win_idx(win_idx),
    .win_lvl(win_lvl)
  );

  assign take = found & ack_i;

  irqv_inservice u_ins (
    .clk(clk), .rst_n(rst_n), .take(take), .take_lvl(win_lvl),
    .reti(reti_i), .ins_hi(ins_hi), .ins_lo(ins_lo)
  );

  assign irq_o    = found;
  assign vector_o = found ? (VEC_W'(VEC_BASE) + VEC_W'(win_idx) * VEC_W'(VEC_STEP)) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_src_o <= '0;
      src_clr_o <= '0;
    end else begin
      src_clr_o <= '0;
      if (take) begin
        ack_src_o <= win_idx;
        src_clr_o <= NSRC'(1) << win_idx;
      end
    end
  end

  // R2: master enable off keeps the request line quiet
  p_gen_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |-> !irq_o);

  // R9: a running high-level handler blocks everything
  p_hi_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ins_hi |-> !irq_o);

  // R8: with the low level busy only a high-level source may be presented
  p_lo_busy_hi_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_lo && irq_o) |-> pri_mask[win_idx]);

  // R7: the clear output never names two sources
  p_clr_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_clr_o));

  // R7: every accept yields exactly one clear bit in the next cycle
  p_clr_after_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ($countones(src_clr_o) == 1));

  // R7: a clear bit only follows an accept
  p_clr_needs_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_clr_o != '0) |-> $past(take));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] req_i = '0;
  logic       en_we_i = 1'b0, pri_we_i = 1'b0, ack_i = 1'b0, reti_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       irq_o;
  logic [15:0] vector_o;
  logic [2:0] ack_src_o;
  logic [4:0] src_clr_o;

  always #2 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .en_we_i(en_we_i),
    .pri_we_i(pri_we_i), .wdata_i(wdata_i), .ack_i(ack_i), .reti_i(reti_i),
    .irq_o(irq_o), .vector_o(vector_o), .ack_src_o(ack_src_o),
    .src_clr_o(src_clr_o)
  );

  int n_run = 0, n_fail = 0;

  // reference model state
  logic [7:0] m_en = '0, m_pri = '0;
  bit  m_hi = 0, m_lo = 0;
  int  m_ack = 0;
  logic [4:0] m_clr = '0;
  logic [4:0] reqv = '0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // expected winner: -1 when nothing qualifies
  function automatic int pick(output bit hi);
    int best = -1;
    hi = 0;
    if (!m_en[7] || m_hi) return -1;
    for (int s = 0; s < 5; s++)
      if (reqv[s] && m_en[s] && m_pri[s]) begin best = s; hi = 1; break; end
    if (best < 0 && !m_lo)
      for (int s = 0; s < 5; s++)
        if (reqv[s] && m_en[s] && !m_pri[s]) begin best = s; break; end
    return best;
  endfunction

  task automatic step(input string tag, input bit wen, input bit wpri,
                      input logic [7:0] d, input bit a, input bit r);
    int w; bit whi; bit acc;
    @(negedge clk);
    reqv = reqv & ~m_clr;         // peripheral drops its flag on the clear pulse
    req_i = reqv; en_we_i = wen; pri_we_i = wpri; wdata_i = d;
    ack_i = a; reti_i = r;
    #1;
    w = pick(whi);
    check(tag, "irq_o", int'(irq_o), (w >= 0) ? 1 : 0);
    check(tag, "vector_o", int'(vector_o), (w >= 0) ? (3 + 8 * w) : 0);
    check(tag, "ack_src_o", int'(ack_src_o), m_ack);
    check(tag, "src_clr_o", int'(src_clr_o), int'(m_clr));
    @(posedge clk);
    acc = a && (w >= 0);
    if (r) begin
      if (m_hi) m_hi = 0; else m_lo = 0;
    end
    m_clr = '0;
    if (acc) begin
      if (whi) m_hi = 1; else m_lo = 1;
      m_ack = w;
      m_clr = 5'(1 << w);
    end
    if (wen)  m_en  = d;
    if (wpri) m_pri = d;
  endtask

  task automatic idle(input string tag); step(tag, 0, 0, 8'h00, 0, 0); endtask

  initial begin : watchdog
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle("R1 reset state");
    reqv = 5'h1F;
    idle("R1 masked after reset");
    step("R2 enable bits without master", 1, 0, 8'h1F, 0, 0);
    idle("R2 master off");
    step("R2 master on", 1, 0, 8'h9F, 0, 0);
    idle("R5 R6 ext A wins low level");
    step("R3 only ext B enabled", 1, 0, 8'h84, 0, 0);
    idle("R3 ext B vector 0x13");
    step("R3 reserved bits only", 1, 0, 8'hE0, 0, 0);
    idle("R3 bits 5 and 6 no effect");
    step("R3 serial only", 1, 0, 8'h90, 0, 0);
    idle("R6 serial vector 0x23");
    step("R4 all enabled", 1, 0, 8'h9F, 0, 0);
    step("R4 timer B high", 0, 1, 8'h08, 0, 0);
    idle("R4 high beats lower index");
    step("R5 two high sources", 0, 1, 8'h0C, 0, 0);
    idle("R5 ext B before timer B");
    step("R7 accept ext B high", 0, 0, 8'h00, 1, 0);
    idle("R7 R9 clear pulse and block");
    idle("R7 R9 pulse gone still blocked");
    step("R10 return from high", 0, 0, 8'h00, 0, 1);
    idle("R11 timer B presented next");
    step("R7 accept timer B", 0, 0, 8'h00, 1, 0);
    idle("R9 blocked");
    step("R10 return from timer B", 0, 0, 8'h00, 0, 1);
    idle("R11 ext A low presented");
    step("R7 accept ext A low", 0, 0, 8'h00, 1, 0);
    idle("R8 low busy blocks low requests");
    reqv = reqv | 5'h04;
    idle("R8 high request preempts low");
    step("R8 accept nested high", 0, 0, 8'h00, 1, 0);
    idle("R9 both levels busy");
    step("R10 first return clears high only", 0, 0, 8'h00, 0, 1);
    idle("R10 low still busy");
    step("R10 second return clears low", 0, 0, 8'h00, 0, 1);
    idle("R11 timer A presented");
    step("R11 accept timer A", 0, 0, 8'h00, 1, 0);
    step("R11 return", 0, 0, 8'h00, 0, 1);
    idle("R11 serial presented");
    step("R11 accept serial", 0, 0, 8'h00, 1, 0);
    step("R11 return", 0, 0, 8'h00, 0, 1);
    idle("R6 all served");
    step("R10 return with none active", 0, 0, 8'h00, 0, 1);
    reqv = 5'h01;
    idle("R10 no effect ext A taken");
    step("R7 ack held off then high arrives", 0, 0, 8'h00, 0, 0);
    reqv = reqv | 5'h08;
    idle("R6 vector follows new winner");
    step("R2 master off with pending", 1, 0, 8'h1F, 0, 0);
    idle("R2 quiet");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule